// File: doc/BRIEF.md
# Low-Water Interrupt Transmit Byte Queue with Line Release

This block buffers bytes from a processor write port toward a serial drain port. The drain side takes bytes whenever it is ready and a byte is marked as visible. An occupancy count goes back to the processor side, so software can work out the free space. A level interrupt tells software that the queue has drained to a programmable low-water mark, which gives it time to refill before the link runs dry.

A mode input sets when written bytes become visible to the drain side.

- **Character mode:** every accepted byte is released at once.
- **Line mode:** bytes stay hidden until a newline byte (0x0A) is accepted. Then everything up to and including that newline is released together.

A release pointer marks the edge of the visible data. The drain side can never read past it. A parameter chooses whether storage is built from per-entry flip-flops or from one inferred memory array. Both choices behave the same.

Top module: `nl_txq`

## Requirements
- R1: While rst_ni is low, and right after it is released, rd_valid_o, count_o, irq_o and ovf_o are all 0.
- R2: With line_mode_i = 0, a byte accepted at an edge is visible on rd_valid_o/rd_data_o after that edge. Bytes come out in write order.
- R3: With line_mode_i = 1, accepted bytes stay invisible (rd_valid_o = 0) until a byte equal to 0x0A is accepted. After the edge that accepts the newline, every held byte through the newline is readable in order.
- R4: With line_mode_i = 1, bytes accepted after the last newline stay hidden, although count_o includes them. A later newline releases them in order, and the queue keeps no stale state.
- R5: count_o equals accepted writes minus completed reads. It updates on the edge where they happen. A read completes only when rd_valid_o and rd_ready_i are both 1.
- R6: A write while count_o equals DEPTH is dropped and sets ovf_o at that edge. ovf_o stays set until ovf_clr_i is high at an edge with no such write. If both happen at the same edge, the set wins.
- R7: At each edge irq_o is loaded with irq_en_i AND (next count <= thresh_i). It therefore stays high while the count sits at or below the threshold and the enable is set.
- R8: STORE_FF = 1 (flip-flop cells) and STORE_FF = 0 (memory array) give identical port behaviour.
- R9: rd_ready_i while rd_valid_o is 0 has no effect on count_o or on the data order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe from processor side |
| wr_data_i | input | 8 | Byte to enqueue |
| line_mode_i | input | 1 | 0 = release per byte, 1 = release on newline |
| thresh_i | input | AW+1 | Low-water interrupt level |
| irq_en_i | input | 1 | Interrupt enable |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| rd_ready_i | input | 1 | Drain side takes the current byte |
| rd_valid_o | output | 1 | A released byte is available |
| rd_data_o | output | 8 | Byte at the head of the queue |
| count_o | output | AW+1 | Bytes held, released or not |
| ovf_o | output | 1 | Sticky: a write was dropped while full |
| irq_o | output | 1 | Low-water interrupt request |

## Verification
The assertions assume the following about the inputs:
- rst_ni goes low at least once before operation.
- line_mode_i, wr_valid_i and wr_data_i are known values at every sampling edge, because the hold and follow properties of the release pointer read them directly.
- thresh_i and irq_en_i may change freely; the interrupt property only relates irq_o to the enable sampled one edge earlier.

The stimulus changes every input on the falling clock edge, never leaves an input unknown, and asserts reset before any traffic. The bench switches modes only when the queue has no hidden bytes, so a mode change never forces a release outside what the stimulus intends.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam logic [7:0] NEWLINE = 8'h0A;

  typedef enum logic {
    REL_CHAR = 1'b0,
    REL_LINE = 1'b1
  } rel_mode_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH    = 64,
  parameter bit STORE_FF = 1'b0,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] cells [DEPTH];

  if (STORE_FF) begin : g_ff
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [7:0] cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              cell_q <= '0;
        else if (we_i && waddr_i == AW'(i))       cell_q <= wdata_i;
      end
      assign cells[i] = cell_q;
    end
  end else begin : g_mem
    logic [7:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      assign cells[i] = mem_q[i];
    end
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  rel_mode_e     mode_i,
  input  logic          ovf_clr_i,
  input  logic          rd_ready_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          rd_valid_o,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] cnt_next_o,
  output logic          ovf_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] wp_q, rp_q, rel_q;
  logic [PW-1:0] wp_n, rp_n, rel_n;
  logic          full, wr_ok, rd_ok, ovf_q;

  assign cnt_o      = wp_q - rp_q;
  assign full       = (cnt_o == FULL_CNT);
  assign wr_ok      = wr_valid_i && !full;
  assign rd_valid_o = (rp_q != rel_q);
  assign rd_ok      = rd_valid_o && rd_ready_i;

  assign wp_n       = wp_q + PW'(wr_ok);
  assign rp_n       = rp_q + PW'(rd_ok);
  assign cnt_next_o = wp_n - rp_n;

  // release boundary: follows writes in char mode, jumps past newline in line mode
  always_comb begin
    rel_n = rel_q;
    if (mode_i == REL_CHAR)                   rel_n = wp_n;
    else if (wr_ok && wr_data_i == NEWLINE)   rel_n = wp_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      rel_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      rel_q <= rel_n;
      if (wr_valid_i && full) ovf_q <= 1'b1;
      else if (ovf_clr_i)     ovf_q <= 1'b0;
    end
  end

  assign we_o    = wr_ok;
  assign waddr_o = wp_q[AW-1:0];
  assign raddr_o = rp_q[AW-1:0];
  assign ovf_o   = ovf_q;

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= FULL_CNT);

  assert_rel_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_q - rp_q) <= (wp_q - rp_q));

  assert_drop_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full) |=> (ovf_o && $stable(wp_q)));

  assert_line_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == REL_LINE && !(wr_valid_i && wr_data_i == NEWLINE)) |=> $stable(rel_q));

  assert_char_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == REL_CHAR) |=> (rel_q == wp_q));

  assert_idle_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |=> $stable(rp_q));
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int PW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_en_i,
  input  logic [PW-1:0] cnt_next_i,
  input  logic [PW-1:0] thresh_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_en_i && (cnt_next_i <= thresh_i);
  end

  assign irq_o = irq_q;

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));
endmodule

// File: rtl/nl_txq.sv
module nl_txq
  import txq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter bit STORE_FF = 1'b0,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          line_mode_i,
  input  logic [PW-1:0] thresh_i,
  input  logic          irq_en_i,
  input  logic          ovf_clr_i,
  input  logic          rd_ready_i,
  output logic          rd_valid_o,
  output logic [7:0]    rd_data_o,
  output logic [PW-1:0] count_o,
  output logic          ovf_o,
  output logic          irq_o
);
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] cnt_next;
  rel_mode_e     mode;

  assign mode = line_mode_i ? REL_LINE : REL_CHAR;

  txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .mode_i     (mode),
    .ovf_clr_i  (ovf_clr_i),
    .rd_ready_i (rd_ready_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .rd_valid_o (rd_valid_o),
    .cnt_o      (count_o),
    .cnt_next_o (cnt_next),
    .ovf_o      (ovf_o)
  );

  txq_store #(.DEPTH(DEPTH), .STORE_FF(STORE_FF)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );

  txq_irq #(.PW(PW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_en_i   (irq_en_i),
    .cnt_next_i (cnt_next),
    .thresh_i   (thresh_i),
    .irq_o      (irq_o)
  );

  assert_valid_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (count_o != '0));

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i && !(rd_valid_o && rd_ready_i) |=> $stable(count_o));
endmodule

// File: tb/nl_txq_bench.sv
module nl_txq_bench;
  localparam int DEPTH = 8;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, line_mode = 1'b0, irq_en = 1'b0, ovf_clr = 1'b0, rd_ready = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [PW-1:0] thresh = '0;
  logic          a_valid, b_valid, a_ovf, b_ovf, a_irq, b_irq;
  logic [7:0]    a_data, b_data;
  logic [PW-1:0] a_cnt, b_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nl_txq #(.DEPTH(DEPTH), .STORE_FF(1'b0)) u_nl_txq (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .line_mode_i(line_mode), .thresh_i(thresh), .irq_en_i(irq_en), .ovf_clr_i(ovf_clr),
    .rd_ready_i(rd_ready), .rd_valid_o(a_valid), .rd_data_o(a_data), .count_o(a_cnt),
    .ovf_o(a_ovf), .irq_o(a_irq));

  nl_txq #(.DEPTH(DEPTH), .STORE_FF(1'b1)) u_nl_txq_ff (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .line_mode_i(line_mode), .thresh_i(thresh), .irq_en_i(irq_en), .ovf_clr_i(ovf_clr),
    .rd_ready_i(rd_ready), .rd_valid_o(b_valid), .rd_data_o(b_data), .count_o(b_cnt),
    .ovf_o(b_ovf), .irq_o(b_irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every check also covers the flip-flop variant (R8)
  task automatic chk_valid(input string req, input int exp);
    chk({req, " valid"}, int'(a_valid), exp);
    chk({req, " valid R8"}, int'(b_valid), exp);
  endtask
  task automatic chk_data(input string req, input int exp);
    chk({req, " data"}, int'(a_data), exp);
    chk({req, " data R8"}, int'(b_data), exp);
  endtask
  task automatic chk_cnt(input string req, input int exp);
    chk({req, " count"}, int'(a_cnt), exp);
    chk({req, " count R8"}, int'(b_cnt), exp);
  endtask
  task automatic chk_ovf(input string req, input int exp);
    chk({req, " ovf"}, int'(a_ovf), exp);
    chk({req, " ovf R8"}, int'(b_ovf), exp);
  endtask
  task automatic chk_irq(input string req, input int exp);
    chk({req, " irq"}, int'(a_irq), exp);
    chk({req, " irq R8"}, int'(b_irq), exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {line, wr_valid, wr_data, rd_ready, exp_valid, exp_data, exp_count}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h41, 1'b0, 1'b1, 8'h41, 4'd1},  // R2
    {1'b0, 1'b1, 8'h42, 1'b1, 1'b1, 8'h42, 4'd1},  // R2 order
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd0},  // R5
    {1'b1, 1'b1, 8'h48, 1'b0, 1'b0, 8'h00, 4'd1},  // R3 held
    {1'b1, 1'b1, 8'h49, 1'b0, 1'b0, 8'h00, 4'd2},  // R3 held
    {1'b1, 1'b1, 8'h0A, 1'b1, 1'b1, 8'h48, 4'd3},  // R3 release, R9 idle read
    {1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 8'h49, 4'd3},  // R4 tail write
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h0A, 4'd2},  // R3
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd1},  // R4 tail hidden
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd1},  // R9
    {1'b1, 1'b1, 8'h0A, 1'b0, 1'b1, 8'h5A, 4'd2},  // R4 released
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h0A, 4'd1},  // R4
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd0}   // R5
  };

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_valid("R1 in reset", 0);
    chk_cnt("R1 in reset", 0);
    chk_ovf("R1 in reset", 0);
    chk_irq("R1 in reset", 0);
    rst_n = 1'b1;
    step();
    chk_valid("R1 after reset", 0);
    chk_cnt("R1 after reset", 0);
    chk_irq("R1 after reset", 0);

    for (int i = 0; i < NV; i++) begin
      line_mode = VEC[i][23];
      wr_valid  = VEC[i][22];
      wr_data   = VEC[i][21:14];
      rd_ready  = VEC[i][13];
      step();
      chk_valid($sformatf("R2-R4 vec%0d", i), int'(VEC[i][12]));
      if (VEC[i][12]) chk_data($sformatf("R2-R4 vec%0d", i), int'(VEC[i][11:4]));
      chk_cnt($sformatf("R5 vec%0d", i), int'(VEC[i][3:0]));
    end
    wr_valid = 1'b0; rd_ready = 1'b0; line_mode = 1'b0;

    // fill to DEPTH in char mode
    for (int i = 0; i < DEPTH; i++) begin
      wr_valid = 1'b1; wr_data = 8'(8'h10 + i);
      step();
    end
    chk_cnt("R5 full", DEPTH);
    chk_ovf("R6 not yet", 0);
    wr_data = 8'hEE;
    step();
    chk_cnt("R6 dropped", DEPTH);
    chk_ovf("R6 set", 1);
    ovf_clr = 1'b1;
    step();
    chk_ovf("R6 set beats clear", 1);
    wr_valid = 1'b0;
    step();
    chk_ovf("R6 cleared", 0);
    ovf_clr = 1'b0;

    // drain with low-water interrupt
    thresh = PW'(2); irq_en = 1'b1;
    step();
    chk_irq("R7 above threshold", 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk_data("R2 drain order", 8'h10 + i);
      rd_ready = 1'b1;
      step();
      chk_cnt("R5 drain", DEPTH - 1 - i);
      chk_irq("R7 drain", ((DEPTH - 1 - i) <= 2) ? 1 : 0);
    end
    chk_valid("R6 dropped byte absent", 0);
    irq_en = 1'b0;
    step();
    chk_irq("R7 disabled", 0);
    rd_ready = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule